// File: doc/BRIEF.md
# RV32I Integer Arithmetic-Logic Unit

This block is the purely combinational execute unit of a 32-bit base-integer RISC-V core. Two operands come in: the first is always a register value, and the second is either a register value or a sign-extended immediate. A 3-bit operation code taken directly from the instruction's funct3 field selects the operation. One extra select bit, taken from bit 5 of funct7 (bit 30 of the instruction), picks between paired variants. A flag marks immediate-form instructions. The block produces one 32-bit result in the same cycle.

In parallel, the unit compares the two operands and drives six branch-condition outputs. The fetch logic uses these to resolve the six conditional branch kinds without a second pass through the datapath. Results wrap modulo 2^32. The unit raises no overflow indication. Multiply, divide and all register-file and memory access sit outside this block.

Top module: `rv_int_alu`

## Requirements
- R1: With `op_sel` = 3'b000, the result is (`src_a` + `src_b`) mod 2^32 whenever `alt_sel` = 0 or `imm_form` = 1.
- R2: With `op_sel` = 3'b000, `alt_sel` = 1 and `imm_form` = 0, the result is (`src_a` - `src_b`) mod 2^32.
- R3: No subtract exists in immediate form: with `op_sel` = 3'b000 and `imm_form` = 1, `alt_sel` has no effect and the result is the sum.
- R4: With `op_sel` = 3'b010, the result is 1 when `src_a` < `src_b` as two's-complement signed numbers, and 0 otherwise.
- R5: With `op_sel` = 3'b011, the result is 1 when `src_a` < `src_b` as unsigned numbers, and 0 otherwise.
- R6: Bitwise operations: `op_sel` = 3'b100 gives XOR, 3'b110 gives OR, and 3'b111 gives AND.
- R7: With `op_sel` = 3'b001, the result is `src_a` shifted left by `src_b[4:0]`, with zeros shifted in. Bits `src_b[31:5]` are ignored.
- R8: With `op_sel` = 3'b101, the result is `src_a` shifted right by `src_b[4:0]`. It is zero-filled when `alt_sel` = 0 and filled with copies of `src_a[31]` when `alt_sel` = 1. This holds in both register and immediate form.
- R9: `br_eq` is 1 exactly when `src_a` == `src_b`, and `br_ne` is its complement.
- R10: `br_lt` is 1 exactly when `src_a` < `src_b` as signed numbers, and `br_ge` is its complement.
- R11: `br_ltu` is 1 exactly when `src_a` < `src_b` as unsigned numbers, and `br_geu` is its complement.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_a | input | 32 | First operand (register value) |
| src_b | input | 32 | Second operand (register value or immediate) |
| op_sel | input | 3 | Operation code, funct3 encoding |
| alt_sel | input | 1 | Variant select, funct7 bit 5 position |
| imm_form | input | 1 | 1 when `src_b` is an immediate |
| result | output | 32 | Operation result |
| br_eq | output | 1 | Operands equal |
| br_ne | output | 1 | Operands differ |
| br_lt | output | 1 | Signed less-than |
| br_ge | output | 1 | Signed greater-or-equal |
| br_ltu | output | 1 | Unsigned less-than |
| br_geu | output | 1 | Unsigned greater-or-equal |

## Verification
Every operation code is applied to every combination of `alt_sel` and `imm_form`, across all ordered pairs of a corner-value set. The set is zero, one, all-ones, the largest positive value, the most negative value, 32, 31 and a mixed bit pattern.

- Pairs that mix sign bits separate the signed comparison from the unsigned one, and also separate arithmetic from logical right shift.
- Shift amounts of 32 and of a value with high bits set show that only the low five bits count.
- The all-ones and extreme values expose any carry or wrap error in the adder.
- Repeating each addition with `alt_sel` set and the immediate flag raised confirms that no immediate subtract appears.

// File: rtl/rv_int_alu.sv
module rv_int_alu #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] src_a,
  input  logic [XLEN-1:0] src_b,
  input  logic [2:0]      op_sel,
  input  logic            alt_sel,
  input  logic            imm_form,
  output logic [XLEN-1:0] result,
  output logic            br_eq,
  output logic            br_ne,
  output logic            br_lt,
  output logic            br_ge,
  output logic            br_ltu,
  output logic            br_geu
);
  localparam int SHW = $clog2(XLEN);

  logic            do_sub;
  logic [XLEN-1:0] b_inv;
  logic [XLEN-1:0] sum;
  logic [SHW-1:0]  sh;
  logic            fill;
  logic [2*XLEN-1:0] sr_wide;
  logic [XLEN-1:0] shr;
  logic [XLEN-1:0] shl;
  logic            ltu;
  logic            lts;

  assign do_sub  = (op_sel == 3'b000) && alt_sel && !imm_form;
  assign b_inv   = do_sub ? ~src_b : src_b;
  assign sum     = src_a + b_inv + {{(XLEN-1){1'b0}}, do_sub};

  assign sh      = src_b[SHW-1:0];
  assign fill    = alt_sel & src_a[XLEN-1];
  assign sr_wide = {{XLEN{fill}}, src_a} >> sh;
  assign shr     = sr_wide[XLEN-1:0];
  assign shl     = src_a << sh;

  assign ltu     = src_a < src_b;
  assign lts     = (src_a[XLEN-1] ^ src_b[XLEN-1]) ? src_a[XLEN-1] : ltu;

  always_comb begin
    unique case (op_sel)
      3'b000:  result = sum;
      3'b001:  result = shl;
      3'b010:  result = {{(XLEN-1){1'b0}}, lts};
      3'b011:  result = {{(XLEN-1){1'b0}}, ltu};
      3'b100:  result = src_a ^ src_b;
      3'b101:  result = shr;
      3'b110:  result = src_a | src_b;
      default: result = src_a & src_b;
    endcase
  end

  assign br_eq  = (src_a == src_b);
  assign br_ne  = ~br_eq;
  assign br_lt  = lts;
  assign br_ge  = ~lts;
  assign br_ltu = ltu;
  assign br_geu = ~ltu;
endmodule

// File: rtl/rv_int_alu_chk.sv
module rv_int_alu_chk #(
  parameter int XLEN = 32
) (
  input logic [XLEN-1:0] src_a,
  input logic [XLEN-1:0] src_b,
  input logic [2:0]      op_sel,
  input logic            alt_sel,
  input logic            imm_form,
  input logic [XLEN-1:0] result,
  input logic            br_eq,
  input logic            br_ne,
  input logic            br_lt,
  input logic            br_ge,
  input logic            br_ltu,
  input logic            br_geu
);
  always_comb begin
    assert_eq_pair_R9: assert (br_eq ^ br_ne);
    assert_signed_pair_R10: assert (br_lt ^ br_ge);
    assert_unsigned_pair_R11: assert (br_ltu ^ br_geu);
    if (op_sel == 3'b010)
      assert_slt_matches_branch_R4: assert (result == {{(XLEN-1){1'b0}}, br_lt});
    if (op_sel == 3'b011)
      assert_sltu_matches_branch_R5: assert (result == {{(XLEN-1){1'b0}}, br_ltu});
    if (op_sel == 3'b000 && imm_form)
      assert_no_imm_sub_R3: assert (result == src_a + src_b);
    if (op_sel == 3'b101 && alt_sel)
      assert_sra_sign_R8: assert (result[XLEN-1] == src_a[XLEN-1]);
    if (op_sel == 3'b000 && br_eq && alt_sel && !imm_form)
      assert_sub_self_zero_R2: assert (result == '0);
  end
endmodule

bind rv_int_alu rv_int_alu_chk #(.XLEN(XLEN)) u_chk (
  .src_a(src_a), .src_b(src_b), .op_sel(op_sel), .alt_sel(alt_sel),
  .imm_form(imm_form), .result(result), .br_eq(br_eq), .br_ne(br_ne),
  .br_lt(br_lt), .br_ge(br_ge), .br_ltu(br_ltu), .br_geu(br_geu)
);

// File: tb/rv_int_alu_test.sv
`timescale 1ns/1ps
module rv_int_alu_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [31:0] src_a = '0, src_b = '0;
  logic [2:0]  op_sel = '0;
  logic        alt_sel = 1'b0, imm_form = 1'b0;
  logic [31:0] result;
  logic br_eq, br_ne, br_lt, br_ge, br_ltu, br_geu;

  rv_int_alu uut (
    .src_a(src_a), .src_b(src_b), .op_sel(op_sel), .alt_sel(alt_sel),
    .imm_form(imm_form), .result(result), .br_eq(br_eq), .br_ne(br_ne),
    .br_lt(br_lt), .br_ge(br_ge), .br_ltu(br_ltu), .br_geu(br_geu)
  );

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [31:0] exp_res_q[$];
  logic [5:0]  exp_br_q[$];
  string       tag_q[$];

  logic [31:0] corners [8] = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h7FFF_FFFF,
                               32'h8000_0000, 32'h20, 32'h1F, 32'hAAAA_5555};

  function automatic logic [31:0] model(logic [31:0] a, logic [31:0] b,
                                        logic [2:0] f, logic alt, logic imm);
    int n = int'(b[4:0]);
    case (f)
      3'b000: return (alt && !imm) ? a - b : a + b;
      3'b001: return a << n;
      3'b010: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      3'b011: return (a < b) ? 32'd1 : 32'd0;
      3'b100: return a ^ b;
      3'b101: return alt ? 32'($signed(a) >>> n) : a >> n;
      3'b110: return a | b;
      default: return a & b;
    endcase
  endfunction

  function automatic string tag_of(logic [2:0] f, logic alt, logic imm);
    case (f)
      3'b000: return imm ? "R1 R3" : (alt ? "R2" : "R1");
      3'b001: return "R7";
      3'b010: return "R4";
      3'b011: return "R5";
      3'b101: return "R8";
      default: return "R6";
    endcase
  endfunction

  task automatic drive(logic [31:0] a, logic [31:0] b, logic [2:0] f,
                       logic alt, logic imm);
    logic lt_s = $signed(a) < $signed(b);
    logic lt_u = a < b;
    @(negedge clk);
    src_a = a; src_b = b; op_sel = f; alt_sel = alt; imm_form = imm;
    exp_res_q.push_back(model(a, b, f, alt, imm));
    exp_br_q.push_back({a == b, a != b, lt_s, !lt_s, lt_u, !lt_u});
    tag_q.push_back(tag_of(f, alt, imm));
  endtask

  always @(posedge clk) begin
    if (exp_res_q.size() > 0) begin
      logic [31:0] er;
      logic [5:0]  eb;
      logic [5:0]  ab;
      string       t;
      er = exp_res_q.pop_front();
      eb = exp_br_q.pop_front();
      t  = tag_q.pop_front();
      ab = {br_eq, br_ne, br_lt, br_ge, br_ltu, br_geu};
      checks++;
      if (result !== er) begin
        fails++;
        $display("FAIL %s: result actual %h expected %h (a=%h b=%h op=%b alt=%b imm=%b)",
                 t, result, er, src_a, src_b, op_sel, alt_sel, imm_form);
      end
      checks++;
      if (ab !== eb) begin
        fails++;
        $display("FAIL R9 R10 R11: branch flags actual %b expected %b (a=%h b=%h)",
                 ab, eb, src_a, src_b);
      end
    end
  end

  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // reset/idle state: zero operands give sum 0 and equal flags (R1, R9)
    drive(32'h0, 32'h0, 3'b000, 1'b0, 1'b0);
    // R7 / R8: upper shift-amount bits ignored
    drive(32'h0000_0001, 32'hFFFF_FFE4, 3'b001, 1'b0, 1'b0);
    drive(32'h8000_0000, 32'h0000_0424, 3'b101, 1'b1, 1'b1);
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++)
        for (int f = 0; f < 8; f++)
          for (int m = 0; m < 4; m++)
            drive(corners[i], corners[j], 3'(f), m[1], m[0]);
    while (exp_res_q.size() > 0) @(posedge clk);
    @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule